// File: doc/BRIEF.md
# Set-Associative Tag Array with Non-Temporal Fill Placement

This block holds the tags, valid bits and per-set recency order of a 16-way set-associative cache. A lookup searches one set for a tag and reports whether it hit and in which way. A hit promotes that line to most recently used. A fill installs a tag into a set. It chooses the way to replace, reports whether a valid line was displaced and what that line's tag was, and places the new line in the recency order.

Fills carry a non-temporal flag. A normal fill chooses its way freely and lands at the most-recently-used end of the order. A non-temporal fill always goes into way 0 of its set and lands at the least-recently-used end. The streaming line is therefore the next candidate for eviction, and a stream can never hold more than one way in sixteen. Data storage and coherence belong to other blocks.

Lookup and fill arrive on separate request ports and may be presented in the same cycle. When both target the same set, the fill is served and the lookup is held off for that cycle through `lookup_ready`.

Top module: `nt_repl_tag_array`

## Requirements
- R1: After synchronous reset every way of every set is invalid, so lookups miss and normal fills to an empty set take ways 0, 1, 2, … in turn. The result strobes are low during and after reset until a request is served.
- R2: An accepted lookup raises `lk_done` for exactly one cycle, one cycle after acceptance. `lk_hit` is 1 when a valid way of the set holds the tag, and `lk_way` gives that way as a 4-bit binary index.
- R3: A lookup hit makes the hit line the most recently used line of its set. A lookup miss leaves the set unchanged.
- R4: A normal fill whose tag is absent allocates the lowest-numbered invalid way, or the least recently used way when the set is full. It then reports `fl_alloc`=1 and the way on `fl_way`. It also reports `fl_evict`=1 together with the displaced tag on `fl_evict_tag` when a valid line was replaced.
- R5: A line installed by a normal fill becomes the most recently used line of its set.
- R6: A non-temporal fill whose tag is absent always allocates way 0, which displaces whatever line way 0 holds, including an earlier non-temporal line.
- R7: A line installed by a non-temporal fill is placed least recently used, so the next normal fill to that full set replaces way 0.
- R8: A non-temporal fill whose tag already hits in the set allocates nothing. It reports `fl_alloc`=0, `fl_evict`=0 and the hit way on `fl_way`, and leaves the recency order unchanged.
- R9: A normal fill whose tag already hits allocates nothing. It reports `fl_alloc`=0 and the hit way, and promotes that line to most recently used.
- R10: When a lookup and a fill target the same set in the same cycle, `lookup_ready` is 0, only the fill is served, and a lookup held over to the next cycle sees the filled line. Requests to different sets are both served in the same cycle.
- R11: An accepted fill raises `fl_done` for exactly one cycle, one cycle after acceptance, with its result fields valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Lookup request present |
| lookup_set | input | 4 | Set index of the lookup |
| lookup_tag | input | 12 | Tag searched by the lookup |
| lookup_ready | output | 1 | Lookup accepted this cycle (low on a same-set fill) |
| fill_valid | input | 1 | Fill request present (always accepted) |
| fill_set | input | 4 | Set index of the fill |
| fill_tag | input | 12 | Tag to install |
| fill_nt | input | 1 | 1 = non-temporal fill |
| lk_done | output | 1 | Lookup result strobe |
| lk_hit | output | 1 | Lookup found the tag |
| lk_way | output | 4 | Way that hit |
| fl_done | output | 1 | Fill result strobe |
| fl_alloc | output | 1 | Fill installed a new line |
| fl_way | output | 4 | Way allocated (or way already holding the tag) |
| fl_evict | output | 1 | A valid line was displaced |
| fl_evict_tag | output | 12 | Tag of the displaced line |

## Verification
Both result groups come from a single register stage. A request driven on the falling edge is accepted at the following rising edge, and its strobe and fields are read at the falling edge after that. `lookup_ready` is combinational and is read in the drive cycle. The bench waits for that one register in every check. It also confirms that each strobe drops in the cycle after it rose. Recency order is never read directly. It is inferred from which way, and which displaced tag, the following fills report.

// File: rtl/nt_repl_pkg.sv
package nt_repl_pkg;

    localparam int WAYS   = 16;
    localparam int RANK_W = $clog2(WAYS);
    localparam int NT_WAY = 0;

    typedef logic [RANK_W-1:0]            way_idx_t;
    typedef logic [WAYS-1:0][RANK_W-1:0]  rank_vec_t;

    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_TO_MRU = 2'd1,
        UPD_TO_LRU = 2'd2
    } upd_mode_e;

    localparam way_idx_t MRU_RANK = way_idx_t'(WAYS - 1);
    localparam way_idx_t NT_IDX   = way_idx_t'(NT_WAY);

    // Reset order: way 0 oldest, last way newest.
    function automatic rank_vec_t init_ranks();
        rank_vec_t r;
        for (int w = 0; w < WAYS; w++) r[w] = way_idx_t'(w);
        return r;
    endfunction

    // True when every rank value occurs exactly once.
    function automatic logic ranks_are_perm(rank_vec_t r);
        logic [WAYS-1:0] seen;
        seen = '0;
        for (int w = 0; w < WAYS; w++) seen[r[w]] = 1'b1;
        return &seen;
    endfunction

endpackage

// File: rtl/nt_tag_match.sv
module nt_tag_match
    import nt_repl_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic [WAYS-1:0]             vld_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
    input  logic [TAG_W-1:0]            tag_i,
    output logic                        hit_o,
    output way_idx_t                    way_o
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld_i[w] && (tags_i[w] == tag_i);
    end

    always_comb begin
        way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) way_o = way_idx_t'(w);
        end
    end

    assign hit_o = |match;

endmodule

// File: rtl/nt_victim_select.sv
module nt_victim_select
    import nt_repl_pkg::*;
(
    input  logic [WAYS-1:0] vld_i,
    input  rank_vec_t       ranks_i,
    input  logic            nt_i,
    output way_idx_t        victim_o,
    output logic            victim_vld_o
);

    logic     free_found;
    way_idx_t free_way;
    way_idx_t lru_way;

    // Lowest-numbered free way.
    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!free_found && !vld_i[w]) begin
                free_found = 1'b1;
                free_way   = way_idx_t'(w);
            end
        end
    end

    // Way holding the oldest rank.
    always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (ranks_i[w] == '0) lru_way = way_idx_t'(w);
        end
    end

    always_comb begin
        if (nt_i)            victim_o = NT_IDX;
        else if (free_found) victim_o = free_way;
        else                 victim_o = lru_way;
    end

    assign victim_vld_o = vld_i[victim_o];

endmodule

// File: rtl/nt_rank_update.sv
module nt_rank_update
    import nt_repl_pkg::*;
(
    input  rank_vec_t ranks_i,
    input  upd_mode_e mode_i,
    input  way_idx_t  way_i,
    output rank_vec_t ranks_o
);

    way_idx_t cur_rank;
    assign cur_rank = ranks_i[way_i];

    always_comb begin
        ranks_o = ranks_i;
        for (int w = 0; w < WAYS; w++) begin
            unique case (mode_i)
                UPD_TO_MRU: begin
                    if (way_idx_t'(w) == way_i)      ranks_o[w] = MRU_RANK;
                    else if (ranks_i[w] > cur_rank)  ranks_o[w] = ranks_i[w] - 1'b1;
                end
                UPD_TO_LRU: begin
                    if (way_idx_t'(w) == way_i)      ranks_o[w] = '0;
                    else if (ranks_i[w] < cur_rank)  ranks_o[w] = ranks_i[w] + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nt_repl_tag_array.sv
module nt_repl_tag_array
    import nt_repl_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int TAG_W = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      lookup_valid,
    input  logic [$clog2(SETS)-1:0]   lookup_set,
    input  logic [TAG_W-1:0]          lookup_tag,
    output logic                      lookup_ready,
    input  logic                      fill_valid,
    input  logic [$clog2(SETS)-1:0]   fill_set,
    input  logic [TAG_W-1:0]          fill_tag,
    input  logic                      fill_nt,
    output logic                      lk_done,
    output logic                      lk_hit,
    output logic [RANK_W-1:0]         lk_way,
    output logic                      fl_done,
    output logic                      fl_alloc,
    output logic [RANK_W-1:0]         fl_way,
    output logic                      fl_evict,
    output logic [TAG_W-1:0]          fl_evict_tag
);

    localparam int SET_W = $clog2(SETS);

    logic [WAYS-1:0]            vld_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
    rank_vec_t                  rank_q [SETS];

    // ---------------- lookup path ----------------
    logic      lk_fire;
    logic      lk_hit_c;
    way_idx_t  lk_way_c;
    upd_mode_e lk_mode;
    rank_vec_t lk_rank_new;

    assign lookup_ready = !(fill_valid && (fill_set == lookup_set));
    assign lk_fire      = lookup_valid && lookup_ready;

    nt_tag_match #(.TAG_W(TAG_W)) i_lk_match (
        .vld_i  (vld_q[lookup_set]),
        .tags_i (tag_q[lookup_set]),
        .tag_i  (lookup_tag),
        .hit_o  (lk_hit_c),
        .way_o  (lk_way_c)
    );

    assign lk_mode = lk_hit_c ? UPD_TO_MRU : UPD_NONE;

    nt_rank_update i_lk_rank (
        .ranks_i (rank_q[lookup_set]),
        .mode_i  (lk_mode),
        .way_i   (lk_way_c),
        .ranks_o (lk_rank_new)
    );

    // ---------------- fill path ----------------
    logic      fh_hit;
    way_idx_t  fh_way;
    way_idx_t  victim;
    logic      victim_vld;
    logic      fl_alloc_c;
    way_idx_t  fl_way_c;
    upd_mode_e fl_mode;
    rank_vec_t fl_rank_new;

    nt_tag_match #(.TAG_W(TAG_W)) i_fl_match (
        .vld_i  (vld_q[fill_set]),
        .tags_i (tag_q[fill_set]),
        .tag_i  (fill_tag),
        .hit_o  (fh_hit),
        .way_o  (fh_way)
    );

    nt_victim_select i_victim (
        .vld_i        (vld_q[fill_set]),
        .ranks_i      (rank_q[fill_set]),
        .nt_i         (fill_nt),
        .victim_o     (victim),
        .victim_vld_o (victim_vld)
    );

    assign fl_alloc_c = !fh_hit;
    assign fl_way_c   = fh_hit ? fh_way : victim;

    always_comb begin
        if (fh_hit)       fl_mode = fill_nt ? UPD_NONE : UPD_TO_MRU;
        else if (fill_nt) fl_mode = UPD_TO_LRU;
        else              fl_mode = UPD_TO_MRU;
    end

    nt_rank_update i_fl_rank (
        .ranks_i (rank_q[fill_set]),
        .mode_i  (fl_mode),
        .way_i   (fl_way_c),
        .ranks_o (fl_rank_new)
    );

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]  <= '0;
                rank_q[s] <= init_ranks();
            end
        end else begin
            if (fill_valid) begin
                rank_q[fill_set] <= fl_rank_new;
                if (fl_alloc_c) vld_q[fill_set][fl_way_c] <= 1'b1;
            end
            if (lk_fire && lk_hit_c) rank_q[lookup_set] <= lk_rank_new;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_valid && fl_alloc_c) tag_q[fill_set][fl_way_c] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_done      <= 1'b0;
            lk_hit       <= 1'b0;
            lk_way       <= '0;
            fl_done      <= 1'b0;
            fl_alloc     <= 1'b0;
            fl_way       <= '0;
            fl_evict     <= 1'b0;
            fl_evict_tag <= '0;
        end else begin
            lk_done <= lk_fire;
            fl_done <= fill_valid;
            if (lk_fire) begin
                lk_hit <= lk_hit_c;
                lk_way <= lk_way_c;
            end
            if (fill_valid) begin
                fl_alloc     <= fl_alloc_c;
                fl_way       <= fl_way_c;
                fl_evict     <= fl_alloc_c && victim_vld;
                fl_evict_tag <= tag_q[fill_set][victim];
            end
        end
    end

    // ---------------- assertions ----------------
    // R10
    same_set_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (lookup_valid && fill_valid && (lookup_set == fill_set)) |=> (!lk_done && fl_done));

    // R6
    nt_way_only_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_nt) |=> (fl_done && (!fl_alloc || fl_way == NT_IDX)));

    // R7
    nt_lru_place_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_nt && !fh_hit) |=> (rank_q[$past(fill_set)][NT_WAY] == '0));

    // R3
    hit_to_mru_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_fire && lk_hit_c) |=> (rank_q[$past(lookup_set)][$past(lk_way_c)] == MRU_RANK));

    // R8
    no_alloc_no_evict_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_done && !fl_alloc) |-> !fl_evict);

    // R5
    rank_perm_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> ranks_are_perm(fl_rank_new));

    // R11
    fill_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !fill_valid |=> !fl_done);

endmodule

// File: tb/test_nt_repl_tag_array.sv
module test_nt_repl_tag_array;

    localparam int CLK_PERIOD = 10;
    localparam int NSTEP      = 20;

    typedef struct packed {
        logic        nt;
        logic [11:0] tag;
        logic [3:0]  way;
        logic        ev;
        logic [11:0] evtag;
    } step_t;

    // Set 5: a streaming line, normal fills around it, repeated streaming.
    localparam step_t STEPS [NSTEP] = '{
        '{1'b1, 12'h5A0, 4'd0,  1'b0, 12'h000},
        '{1'b0, 12'h501, 4'd1,  1'b0, 12'h000},
        '{1'b0, 12'h502, 4'd2,  1'b0, 12'h000},
        '{1'b0, 12'h503, 4'd3,  1'b0, 12'h000},
        '{1'b0, 12'h504, 4'd4,  1'b0, 12'h000},
        '{1'b0, 12'h505, 4'd5,  1'b0, 12'h000},
        '{1'b0, 12'h506, 4'd6,  1'b0, 12'h000},
        '{1'b0, 12'h507, 4'd7,  1'b0, 12'h000},
        '{1'b0, 12'h508, 4'd8,  1'b0, 12'h000},
        '{1'b0, 12'h509, 4'd9,  1'b0, 12'h000},
        '{1'b0, 12'h50A, 4'd10, 1'b0, 12'h000},
        '{1'b0, 12'h50B, 4'd11, 1'b0, 12'h000},
        '{1'b0, 12'h50C, 4'd12, 1'b0, 12'h000},
        '{1'b0, 12'h50D, 4'd13, 1'b0, 12'h000},
        '{1'b0, 12'h50E, 4'd14, 1'b0, 12'h000},
        '{1'b0, 12'h50F, 4'd15, 1'b0, 12'h000},
        '{1'b0, 12'h510, 4'd0,  1'b1, 12'h5A0},
        '{1'b0, 12'h511, 4'd1,  1'b1, 12'h501},
        '{1'b1, 12'h5A1, 4'd0,  1'b1, 12'h510},
        '{1'b0, 12'h512, 4'd0,  1'b1, 12'h5A1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lookup_valid = 1'b0;
    logic [3:0]  lookup_set = '0;
    logic [11:0] lookup_tag = '0;
    logic        lookup_ready;
    logic        fill_valid = 1'b0;
    logic [3:0]  fill_set = '0;
    logic [11:0] fill_tag = '0;
    logic        fill_nt = 1'b0;
    logic        lk_done, lk_hit;
    logic [3:0]  lk_way;
    logic        fl_done, fl_alloc, fl_evict;
    logic [3:0]  fl_way;
    logic [11:0] fl_evict_tag;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nt_repl_tag_array i_nt_repl_tag_array (
        .clk, .rst,
        .lookup_valid, .lookup_set, .lookup_tag, .lookup_ready,
        .fill_valid, .fill_set, .fill_tag, .fill_nt,
        .lk_done, .lk_hit, .lk_way,
        .fl_done, .fl_alloc, .fl_way, .fl_evict, .fl_evict_tag
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_op(input logic [3:0] s, input logic [11:0] t, input logic nt,
                           input logic ealloc, input logic [3:0] eway,
                           input logic eev, input logic [11:0] evt, input string req);
        @(negedge clk);
        fill_valid = 1'b1; fill_set = s; fill_tag = t; fill_nt = nt;
        @(negedge clk);
        fill_valid = 1'b0; fill_nt = 1'b0;
        chk({req, " fl_done"}, 32'(fl_done), 32'd1);
        chk({req, " fl_alloc"}, 32'(fl_alloc), 32'(ealloc));
        chk({req, " fl_way"}, 32'(fl_way), 32'(eway));
        chk({req, " fl_evict"}, 32'(fl_evict), 32'(eev));
        if (eev) chk({req, " fl_evict_tag"}, 32'(fl_evict_tag), 32'(evt));
    endtask

    task automatic look_op(input logic [3:0] s, input logic [11:0] t,
                           input logic ehit, input logic [3:0] eway, input string req);
        @(negedge clk);
        lookup_valid = 1'b1; lookup_set = s; lookup_tag = t;
        @(negedge clk);
        lookup_valid = 1'b0;
        chk({req, " lk_done"}, 32'(lk_done), 32'd1);
        chk({req, " lk_hit"}, 32'(lk_hit), 32'(ehit));
        if (ehit) chk({req, " lk_way"}, 32'(lk_way), 32'(eway));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 lk_done in reset", 32'(lk_done), 32'd0);
        chk("R1 fl_done in reset", 32'(fl_done), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 lk_done after reset", 32'(lk_done), 32'd0);
        look_op(4'd3, 12'h300, 1'b0, 4'd0, "R1 R2 miss after reset");

        // R4 R1: fill set 3 in order, then look each line up (R2)
        for (int i = 0; i < 16; i++)
            fill_op(4'd3, 12'h300 + 12'(i), 1'b0, 1'b1, 4'(i), 1'b0, 12'h0, "R1 R4 empty ways");
        for (int i = 0; i < 16; i++)
            look_op(4'd3, 12'h300 + 12'(i), 1'b1, 4'(i), "R2 hit way");
        look_op(4'd3, 12'h3FF, 1'b0, 4'd0, "R2 miss");

        // R11: strobe lasts one cycle
        @(negedge clk);
        chk("R11 fl_done drops", 32'(fl_done), 32'd0);
        chk("R2 lk_done drops", 32'(lk_done), 32'd0);

        // R3 R5: lookup hit on way 1 protects it from replacement
        look_op(4'd3, 12'h301, 1'b1, 4'd1, "R3 hit");
        fill_op(4'd3, 12'h320, 1'b0, 1'b1, 4'd0, 1'b1, 12'h300, "R4 R5 lru victim");
        fill_op(4'd3, 12'h321, 1'b0, 1'b1, 4'd2, 1'b1, 12'h302, "R3 R5 touched way skipped");

        // Table walk: R6 R7 on set 5
        for (int i = 0; i < NSTEP; i++)
            fill_op(4'd5, STEPS[i].tag, STEPS[i].nt, 1'b1, STEPS[i].way, STEPS[i].ev, STEPS[i].evtag,
                    STEPS[i].nt ? "R6 R7 table nt" : "R4 R5 R7 table normal");

        // R6: second streaming fill replaces the first one in way 0
        fill_op(4'd7, 12'h7A0, 1'b1, 1'b1, 4'd0, 1'b0, 12'h0, "R6 first nt");
        fill_op(4'd7, 12'h7A1, 1'b1, 1'b1, 4'd0, 1'b1, 12'h7A0, "R6 second nt");

        // R8: non-temporal fill that hits
        for (int i = 0; i < 16; i++)
            fill_op(4'd9, 12'h900 + 12'(i), 1'b0, 1'b1, 4'(i), 1'b0, 12'h0, "R4 fill set 9");
        fill_op(4'd9, 12'h905, 1'b1, 1'b0, 4'd5, 1'b0, 12'h0, "R8 nt hit");
        fill_op(4'd9, 12'h920, 1'b0, 1'b1, 4'd0, 1'b1, 12'h900, "R8 order unchanged a");
        fill_op(4'd9, 12'h921, 1'b0, 1'b1, 4'd1, 1'b1, 12'h901, "R8 order unchanged b");

        // R9: normal fill that hits promotes the line
        fill_op(4'd9, 12'h902, 1'b0, 1'b0, 4'd2, 1'b0, 12'h0, "R9 normal hit");
        fill_op(4'd9, 12'h922, 1'b0, 1'b1, 4'd3, 1'b1, 12'h903, "R9 promoted way skipped");

        // R10: same-set collision
        @(negedge clk);
        lookup_valid = 1'b1; lookup_set = 4'd9; lookup_tag = 12'h930;
        fill_valid = 1'b1; fill_set = 4'd9; fill_tag = 12'h930; fill_nt = 1'b0;
        #1;
        chk("R10 lookup_ready low", 32'(lookup_ready), 32'd0);
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R10 lk_done stalled", 32'(lk_done), 32'd0);
        chk("R10 fill served", 32'(fl_done), 32'd1);
        chk("R10 fill way", 32'(fl_way), 32'd4);
        chk("R10 fill evict tag", 32'(fl_evict_tag), 32'h904);
        #1;
        chk("R10 lookup_ready high", 32'(lookup_ready), 32'd1);
        @(negedge clk);
        lookup_valid = 1'b0;
        chk("R10 held lookup done", 32'(lk_done), 32'd1);
        chk("R10 held lookup hit", 32'(lk_hit), 32'd1);
        chk("R10 held lookup way", 32'(lk_way), 32'd4);

        // R10: different sets in the same cycle
        @(negedge clk);
        lookup_valid = 1'b1; lookup_set = 4'd3; lookup_tag = 12'h305;
        fill_valid = 1'b1; fill_set = 4'd12; fill_tag = 12'hC00; fill_nt = 1'b1;
        #1;
        chk("R10 diff set ready", 32'(lookup_ready), 32'd1);
        @(negedge clk);
        lookup_valid = 1'b0; fill_valid = 1'b0; fill_nt = 1'b0;
        chk("R10 diff set lk_done", 32'(lk_done), 32'd1);
        chk("R10 diff set lk_way", 32'(lk_way), 32'd5);
        chk("R10 R6 diff set fl_way", 32'(fl_way), 32'd0);
        chk("R10 diff set fl_done", 32'(fl_done), 32'd1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule